// File: doc/BRIEF.md
# NAND Identification Read Sequencer

This block sits on the host side of an 8-bit multiplexed NAND bus and runs the device identification exchange. One pulse on `start` makes it select the device and write the identification opcode 90h in a command-latch cycle. An address-latch cycle carrying 00h follows. After a short turnaround gap it pulses the read strobe once for each identification byte and stores each returned byte in its own lane of a register bank. The first byte is the manufacturer code. The next four are the device code and the third, fourth and fifth identification bytes.

When the sequence ends, the captured bytes are compared with an expected signature supplied by the caller, and the block raises either `match` or `mismatch` together with `done`. A device left in identification mode keeps answering as an ID source until it sees another command. For that reason the caller can ask for a trailing 00h command cycle, which makes a later status read (70h) return real status. The data-valid point after each read-strobe falling edge is set per run by `samp_dly`, so slow and fast parts can share the same logic.

Top module: `nand_id_reader`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block goes to idle: `nd_ce_n`, `nd_we_n` and `nd_re_n` high, `nd_cle`, `nd_ale` and `nd_dq_oe` low, and `busy`, `done`, `match`, `mismatch` and `id_bytes` all zero.
- R2: A `start` seen while idle begins a run. The run first writes opcode 90h with `nd_cle` high, then writes exactly one address byte 00h with `nd_ale` high. Each byte is held on `nd_dq_o` with `nd_dq_oe` high while `nd_we_n` is low for WE_LO cycles and then high for WE_HI cycles.
- R3: GAP cycles after the address cycle, `nd_re_n` pulses NUM_BYTES times. Each low phase lasts `samp_dly`+1 cycles and each high phase lasts RE_HI cycles.
- R4: Read byte k (k = 0 is the manufacturer code) is taken from `nd_dq_i` at the clock edge that ends its last low cycle, and it is stored in `id_bytes[8k+7:8k]`.
- R5: When `exit_en` was high at start, one further command cycle writing 00h follows the last read pulse. When it was low, no command follows the 90h.
- R6: `done` rises when the run completes, with `nd_ce_n` high and `busy` low. It stays high until the next accepted `start`, which clears both `done` and `id_bytes` on the following edge.
- R7: `match` equals `done` AND (all NUM_BYTES lanes equal the expected bytes), and `mismatch` equals `done` AND NOT that; both are low while `done` is low.
- R8: `exp_id`, `samp_dly` and `exit_en` are latched when a run is accepted. Changes to them during a run do not affect that run.
- R9: A `start` pulse while `busy` is high is ignored. No second 90h is issued and the run in progress finishes as if the pulse had not occurred.
- R10: `nd_we_n` and `nd_re_n` are never low together, and `nd_cle` and `nd_ale` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request one identification run |
| exp_id | input | NUM_BYTES*8 | Expected signature, lane 0 = manufacturer byte |
| samp_dly | input | DLY_W | Extra low cycles of each read pulse before sampling |
| exit_en | input | 1 | Issue a trailing 00h command after the reads |
| nd_ce_n | output | 1 | Device select, active low |
| nd_cle | output | 1 | Command latch enable |
| nd_ale | output | 1 | Address latch enable |
| nd_we_n | output | 1 | Write strobe, active low, latches on rising edge |
| nd_re_n | output | 1 | Read strobe, active low |
| nd_dq_o | output | 8 | Bus data driven by the host |
| nd_dq_oe | output | 1 | Host drives the bus when high |
| nd_dq_i | input | 8 | Bus data returned by the device |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run completed |
| id_bytes | output | NUM_BYTES*8 | Captured identification bytes |
| match | output | 1 | Captured bytes equal the expected signature |
| mismatch | output | 1 | Captured bytes differ from the expected signature |

## Verification
The properties assume that `start`, `exp_id`, `samp_dly`, `exit_en` and `nd_dq_i` are synchronous to `clk`. They also assume that the device returns a byte within `samp_dly` cycles of the read-strobe fall, since a slower device would produce a mismatch. The bench changes every input on the falling clock edge. Its device model releases valid data a chosen number of cycles after each strobe fall, and it sets up one run where that delay is longer than the programmed sampling point, so the run returns invalid data. `start` is only pulsed while busy in the run built for R9.

// File: rtl/nrid_pkg.sv
// nrid_pkg: shared encodings for the identification sequencer.
// Assumes an 8-bit multiplexed NAND bus.
package nrid_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CMD  = 3'd1,
        ST_ADDR = 3'd2,
        ST_GAP  = 3'd3,
        ST_READ = 3'd4,
        ST_EXIT = 3'd5
    } nrid_state_t;

    localparam logic [7:0] OP_READ_ID = 8'h90;
    localparam logic [7:0] ADDR_ID    = 8'h00;
    localparam logic [7:0] OP_DUMMY   = 8'h00;

endpackage

// File: rtl/nrid_ctrl.sv
// nrid_ctrl: sequencing state machine with one shared phase counter.
// Walks command, address, gap, read pulses and optional exit command.
// Each strobe phase is split into a low half (lo=1) and a high half.
// Assumes NUM_BYTES >= 2 and all cycle parameters >= 1.
module nrid_ctrl
    import nrid_pkg::*;
#(
    parameter int NUM_BYTES = 5,
    parameter int DLY_W     = 3,
    parameter int WE_LO     = 2,
    parameter int WE_HI     = 2,
    parameter int RE_HI     = 2,
    parameter int GAP       = 4,
    parameter int IW        = $clog2(NUM_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DLY_W-1:0] samp_dly,
    input  logic             exit_en,
    output nrid_state_t      st,
    output logic             lo,
    output logic             cap_en,
    output logic [IW-1:0]    cap_idx,
    output logic             accept,
    output logic             busy,
    output logic             done
);

    localparam int M1   = (WE_LO > WE_HI) ? WE_LO : WE_HI;
    localparam int M2   = (RE_HI > GAP) ? RE_HI : GAP;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int TMAX = (M3 > (1 << DLY_W)) ? M3 : (1 << DLY_W);
    localparam int CW   = $clog2(TMAX + 1);

    localparam logic [CW-1:0] LD_WLO = CW'(WE_LO - 1);
    localparam logic [CW-1:0] LD_WHI = CW'(WE_HI - 1);
    localparam logic [CW-1:0] LD_RHI = CW'(RE_HI - 1);
    localparam logic [CW-1:0] LD_GAP = CW'(GAP - 1);
    localparam logic [IW-1:0] LAST   = IW'(NUM_BYTES - 1);

    logic [CW-1:0]    cnt;
    logic [DLY_W-1:0] dly_q;
    logic             ex_q;
    logic             expired;

    // Phase counter has run out in the current half-phase.
    assign expired = (cnt == '0);

    // Start is taken only from idle; busy flags any other state.
    assign accept  = (st == ST_IDLE) && start;
    assign busy    = (st != ST_IDLE);

    // Capture at the edge that closes the last low cycle of a read pulse.
    assign cap_en  = (st == ST_READ) && lo && expired;

    // Main sequencer: state, half-phase, counter, byte index, done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            lo      <= 1'b0;
            cnt     <= '0;
            cap_idx <= '0;
            done    <= 1'b0;
            dly_q   <= '0;
            ex_q    <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st      <= ST_CMD;
                        lo      <= 1'b1;
                        cnt     <= LD_WLO;
                        done    <= 1'b0;
                        dly_q   <= samp_dly;
                        ex_q    <= exit_en;
                        cap_idx <= '0;
                    end
                end
                ST_CMD, ST_ADDR, ST_EXIT: begin
                    if (!expired) begin
                        cnt <= cnt - CW'(1);
                    end else if (lo) begin
                        lo  <= 1'b0;
                        cnt <= LD_WHI;
                    end else if (st == ST_CMD) begin
                        st  <= ST_ADDR;
                        lo  <= 1'b1;
                        cnt <= LD_WLO;
                    end else if (st == ST_ADDR) begin
                        st  <= ST_GAP;
                        cnt <= LD_GAP;
                    end else begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end
                end
                ST_GAP: begin
                    if (!expired) begin
                        cnt <= cnt - CW'(1);
                    end else begin
                        st      <= ST_READ;
                        lo      <= 1'b1;
                        cnt     <= CW'(dly_q);
                        cap_idx <= '0;
                    end
                end
                ST_READ: begin
                    if (!expired) begin
                        cnt <= cnt - CW'(1);
                    end else if (lo) begin
                        lo  <= 1'b0;
                        cnt <= LD_RHI;
                    end else if (cap_idx == LAST) begin
                        if (ex_q) begin
                            st  <= ST_EXIT;
                            lo  <= 1'b1;
                            cnt <= LD_WLO;
                        end else begin
                            st   <= ST_IDLE;
                            done <= 1'b1;
                        end
                    end else begin
                        cap_idx <= cap_idx + IW'(1);
                        lo      <= 1'b1;
                        cnt     <= CW'(dly_q);
                    end
                end
                default: begin
                    st <= ST_IDLE;
                    lo <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/nrid_pins.sv
// nrid_pins: decodes the sequencer state into bus pin levels.
// Assumes st and lo come straight from registers, so the pins
// change only once per clock and do not glitch between states.
module nrid_pins
    import nrid_pkg::*;
(
    input  nrid_state_t st,
    input  logic        lo,
    output logic        ce_n,
    output logic        cle,
    output logic        ale,
    output logic        we_n,
    output logic        re_n,
    output logic [7:0]  dq_o,
    output logic        dq_oe
);

    logic wr_cyc;

    // Pin levels for each state and half-phase.
    always_comb begin
        wr_cyc = (st == ST_CMD) || (st == ST_ADDR) || (st == ST_EXIT);
        ce_n   = (st == ST_IDLE);
        cle    = (st == ST_CMD) || (st == ST_EXIT);
        ale    = (st == ST_ADDR);
        dq_oe  = wr_cyc;
        we_n   = !(wr_cyc && lo);
        re_n   = !((st == ST_READ) && lo);
        case (st)
            ST_CMD:  dq_o = OP_READ_ID;
            ST_ADDR: dq_o = ADDR_ID;
            ST_EXIT: dq_o = OP_DUMMY;
            default: dq_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/nrid_bank.sv
// nrid_bank: per-lane capture registers and signature compare.
// The expected signature is latched when a run is accepted, and the
// captured lanes are cleared at that point. Result flags are gated by done.
module nrid_bank #(
    parameter int NUM_BYTES = 5,
    parameter int IW        = $clog2(NUM_BYTES),
    parameter int BW        = NUM_BYTES * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [BW-1:0] exp_id,
    input  logic          cap_en,
    input  logic [IW-1:0] cap_idx,
    input  logic [7:0]    dq_i,
    input  logic          done,
    output logic [BW-1:0] id_bytes,
    output logic          match,
    output logic          mismatch
);

    logic [BW-1:0]        exp_q;
    logic [NUM_BYTES-1:0] lane_eq;
    logic                 all_eq;

    // Hold the expected signature for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
        end else if (accept) begin
            exp_q <= exp_id;
        end
    end

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_lane
        // Lane k: clear on accept, load when its read pulse is sampled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                id_bytes[8*k +: 8] <= 8'h00;
            end else if (accept) begin
                id_bytes[8*k +: 8] <= 8'h00;
            end else if (cap_en && (cap_idx == IW'(k))) begin
                id_bytes[8*k +: 8] <= dq_i;
            end
        end
        assign lane_eq[k] = (id_bytes[8*k +: 8] == exp_q[8*k +: 8]);
    end

    // Reduce the per-lane compares and gate the result with done.
    always_comb begin
        all_eq   = &lane_eq;
        match    = done && all_eq;
        mismatch = done && !all_eq;
    end

endmodule

// File: rtl/nand_id_reader.sv
// nand_id_reader: top level of the identification sequencer.
// Assumes every input is synchronous to clk and that the device
// drives valid data within samp_dly cycles of a read-strobe fall.
module nand_id_reader
    import nrid_pkg::*;
#(
    parameter int NUM_BYTES = 5,
    parameter int DLY_W     = 3,
    parameter int WE_LO     = 2,
    parameter int WE_HI     = 2,
    parameter int RE_HI     = 2,
    parameter int GAP       = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NUM_BYTES*8-1:0] exp_id,
    input  logic [DLY_W-1:0]       samp_dly,
    input  logic                   exit_en,
    output logic                   nd_ce_n,
    output logic                   nd_cle,
    output logic                   nd_ale,
    output logic                   nd_we_n,
    output logic                   nd_re_n,
    output logic [7:0]             nd_dq_o,
    output logic                   nd_dq_oe,
    input  logic [7:0]             nd_dq_i,
    output logic                   busy,
    output logic                   done,
    output logic [NUM_BYTES*8-1:0] id_bytes,
    output logic                   match,
    output logic                   mismatch
);

    localparam int IW = $clog2(NUM_BYTES);

    nrid_state_t   st;
    logic          lo;
    logic          cap_en;
    logic [IW-1:0] cap_idx;
    logic          accept;

    nrid_ctrl #(
        .NUM_BYTES (NUM_BYTES),
        .DLY_W     (DLY_W),
        .WE_LO     (WE_LO),
        .WE_HI     (WE_HI),
        .RE_HI     (RE_HI),
        .GAP       (GAP),
        .IW        (IW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .samp_dly (samp_dly),
        .exit_en  (exit_en),
        .st       (st),
        .lo       (lo),
        .cap_en   (cap_en),
        .cap_idx  (cap_idx),
        .accept   (accept),
        .busy     (busy),
        .done     (done)
    );

    nrid_pins u_pins (
        .st    (st),
        .lo    (lo),
        .ce_n  (nd_ce_n),
        .cle   (nd_cle),
        .ale   (nd_ale),
        .we_n  (nd_we_n),
        .re_n  (nd_re_n),
        .dq_o  (nd_dq_o),
        .dq_oe (nd_dq_oe)
    );

    nrid_bank #(
        .NUM_BYTES (NUM_BYTES),
        .IW        (IW)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .exp_id   (exp_id),
        .cap_en   (cap_en),
        .cap_idx  (cap_idx),
        .dq_i     (nd_dq_i),
        .done     (done),
        .id_bytes (id_bytes),
        .match    (match),
        .mismatch (mismatch)
    );

endmodule

// File: rtl/nrid_chk.sv
// nrid_chk: protocol and result-flag properties for nand_id_reader.
// Attached to every instance of the top through the bind below.
module nrid_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic match,
    input logic mismatch,
    input logic ce_n,
    input logic cle,
    input logic ale,
    input logic we_n,
    input logic re_n,
    input logic dq_oe
);

    // R10: the two strobes never overlap.
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    // R10: command and address latch enables never overlap.
    a_r10_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    // R2: the bus is driven whenever the write strobe is low.
    a_r2_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> dq_oe);

    // R1: when idle, all pins rest in their inactive levels.
    a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ce_n && we_n && re_n && !dq_oe));

    // R7: the two result flags are exclusive.
    a_r7_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(match && mismatch));

    // R7: a result flag is raised only with done.
    a_r7_flags_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (match || mismatch) |-> done);

    // R6: done is held until a start arrives.
    a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R6: done means the device is deselected and the block is idle.
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ce_n && !busy));

    // R6: an accepted start clears done and begins a run.
    a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

endmodule

bind nand_id_reader nrid_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .match    (match),
    .mismatch (mismatch),
    .ce_n     (nd_ce_n),
    .cle      (nd_cle),
    .ale      (nd_ale),
    .we_n     (nd_we_n),
    .re_n     (nd_re_n),
    .dq_oe    (nd_dq_oe)
);

// File: tb/sim_nand_id_reader.sv
// sim_nand_id_reader: vector-driven bench with a small device model.
module sim_nand_id_reader;

    localparam int CLK_PER = 10;
    localparam logic [39:0] SIG_8G = 40'h5A15D1D301;
    localparam logic [39:0] SIG_4G = 40'h561590DC01;
    localparam logic [39:0] SIG_EE = 40'hEEEEEEEEEE;

    typedef struct packed {
        logic [39:0] exp;
        logic [39:0] dev;
        logic [2:0]  dly;
        logic        ex;
        logic [1:0]  acc;
        logic        ok;
    } vec_t;

    localparam vec_t VEC [0:5] = '{
        '{SIG_8G, SIG_8G,        3'd0, 1'b1, 2'd0, 1'b1},
        '{SIG_4G, SIG_4G,        3'd3, 1'b0, 2'd0, 1'b1},
        '{SIG_8G, SIG_4G,        3'd1, 1'b1, 2'd0, 1'b0},
        '{SIG_8G, 40'h5B15D1D301, 3'd2, 1'b0, 2'd0, 1'b0},
        '{SIG_4G, SIG_4G,        3'd1, 1'b1, 2'd2, 1'b0},
        '{SIG_4G, SIG_4G,        3'd2, 1'b0, 2'd2, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [39:0] exp_id = '0;
    logic [2:0]  samp_dly = '0;
    logic        exit_en = 1'b0;
    logic [7:0]  nd_dq_i = 8'hFF;
    logic        nd_ce_n, nd_cle, nd_ale, nd_we_n, nd_re_n, nd_dq_oe;
    logic [7:0]  nd_dq_o;
    logic        busy, done, match, mismatch;
    logic [39:0] id_bytes;

    int total = 0;
    int bad = 0;
    int ncmd = 0;
    int naddr = 0;
    int nre = 0;
    int badw = 0;
    int want_w = 1;
    int lowcnt = 0;
    int ptr = 0;
    int acc = 0;
    logic [39:0] dev_id = '0;
    logic [7:0]  cmd_log [0:7];
    logic [7:0]  addr_log;

    always #(CLK_PER/2) clk = ~clk;

    nand_id_reader u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .exp_id(exp_id),
        .samp_dly(samp_dly), .exit_en(exit_en),
        .nd_ce_n(nd_ce_n), .nd_cle(nd_cle), .nd_ale(nd_ale),
        .nd_we_n(nd_we_n), .nd_re_n(nd_re_n), .nd_dq_o(nd_dq_o),
        .nd_dq_oe(nd_dq_oe), .nd_dq_i(nd_dq_i),
        .busy(busy), .done(done), .id_bytes(id_bytes),
        .match(match), .mismatch(mismatch)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exv);
        end
    endtask

    // Device model, write side: log latched command and address bytes.
    initial begin
        forever begin
            @(posedge nd_we_n);
            if (rst_n && nd_cle) begin
                if (ncmd < 8) cmd_log[ncmd] = nd_dq_o;
                ncmd++;
                if (nd_dq_o == 8'h90) ptr = 0;
            end else if (rst_n && nd_ale) begin
                addr_log = nd_dq_o;
                naddr++;
            end
        end
    end

    // Device model, read side: invalid data until acc clocks after the fall.
    initial begin
        forever begin
            @(negedge nd_re_n);
            begin
                int k;
                k = ptr;
                ptr++;
                nd_dq_i = 8'hEE;
                repeat (acc) @(posedge clk);
                #1 nd_dq_i = (k < 5) ? dev_id[8*k +: 8] : 8'hFF;
            end
        end
    end

    // Read-pulse monitor: counts pulses and flags wrong low widths.
    initial begin
        forever begin
            @(negedge clk);
            if (!nd_re_n) lowcnt++;
            else if (lowcnt != 0) begin
                nre++;
                if (lowcnt != want_w) badw++;
                lowcnt = 0;
            end
        end
    end

    task automatic clear_log();
        ncmd = 0; naddr = 0; nre = 0; badw = 0;
        addr_log = 8'hFF;
        for (int i = 0; i < 8; i++) cmd_log[i] = 8'hFF;
    endtask

    task automatic wait_done();
        int g = 0;
        while (!done && g < 2000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic run_seq(input logic [39:0] e, input logic [2:0] d, input logic x);
        clear_log();
        want_w = int'(d) + 1;
        exp_id = e; samp_dly = d; exit_en = x; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL R6 watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(nd_ce_n && nd_we_n && nd_re_n, "R1 strobes", {61'd0, nd_ce_n, nd_we_n, nd_re_n}, 64'h7);
        chk(!nd_cle && !nd_ale && !nd_dq_oe, "R1 latches", {61'd0, nd_cle, nd_ale, nd_dq_oe}, 64'h0);
        chk(!busy && !done && !match && !mismatch, "R1 flags", {60'd0, busy, done, match, mismatch}, 64'h0);
        chk(id_bytes == 40'h0, "R1 id_bytes", {24'd0, id_bytes}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 6; v++) begin
            logic [39:0] want_id;
            dev_id = VEC[v].dev;
            acc = int'(VEC[v].acc);
            want_id = (VEC[v].acc <= VEC[v].dly) ? VEC[v].dev : SIG_EE;
            run_seq(VEC[v].exp, VEC[v].dly, VEC[v].ex);
            chk(done && nd_ce_n && !busy, "R6 done", {61'd0, done, nd_ce_n, busy}, 64'h6);
            chk(id_bytes == want_id, "R4 bytes", {24'd0, id_bytes}, {24'd0, want_id});
            chk(match == VEC[v].ok && mismatch == !VEC[v].ok, "R7 result",
                {62'd0, match, mismatch}, {62'd0, VEC[v].ok, !VEC[v].ok});
            chk(cmd_log[0] == 8'h90 && naddr == 1 && addr_log == 8'h00, "R2 cmd/addr",
                {40'd0, cmd_log[0], addr_log, 8'(naddr)}, {40'd0, 8'h90, 8'h00, 8'd1});
            chk(nre == 5 && badw == 0, "R3 read pulses", {32'(nre), 32'(badw)}, {32'd5, 32'd0});
            if (VEC[v].ex)
                chk(ncmd == 2 && cmd_log[1] == 8'h00, "R5 exit cmd", {32'(ncmd), 24'd0, cmd_log[1]}, {32'd2, 32'h0});
            else
                chk(ncmd == 1, "R5 no exit cmd", 64'(ncmd), 64'd1);
        end

        // R6: done holds while idle, then a start clears done and lanes
        repeat (5) @(negedge clk);
        chk(done == 1'b1, "R6 hold", {63'd0, done}, 64'd1);
        dev_id = SIG_8G; acc = 0;
        clear_log(); want_w = 2;
        exp_id = SIG_8G; samp_dly = 3'd1; exit_en = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done && busy && id_bytes == 40'h0, "R6 start clears",
            {22'd0, done, busy, id_bytes}, {22'd0, 1'b0, 1'b1, 40'h0});
        // R7: flags stay low during a run
        chk(!match && !mismatch, "R7 gated", {62'd0, match, mismatch}, 64'd0);
        // R8 and R9: change inputs and pulse start while busy
        repeat (8) @(negedge clk);
        exp_id = 40'h0; samp_dly = 3'd7; exit_en = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(ncmd == 1, "R9 no second 90h", 64'(ncmd), 64'd1);
        chk(match && !mismatch, "R8 expected latched", {62'd0, match, mismatch}, 64'h2);
        chk(nre == 5 && badw == 0, "R8 delay latched", {32'(nre), 32'(badw)}, {32'd5, 32'd0});

        // R1: reset in mid run returns the pins to idle
        exp_id = SIG_8G; samp_dly = 3'd2; exit_en = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (14) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(nd_ce_n && nd_we_n && nd_re_n && !nd_dq_oe && !busy && !done && id_bytes == 40'h0,
            "R1 mid-run reset", {58'd0, nd_ce_n, nd_we_n, nd_re_n, nd_dq_oe, busy, done}, 64'h38);
        rst_n = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule